// File: doc/BRIEF.md
# Debug Port Scan Data Register

This block is the target-side data register that a JTAG TAP selects when either of two debug instructions is loaded. One instruction reaches the debug-port registers and the other reaches the access-port registers. A debugger shifts a 35-bit frame through it. The frame carries a 3-bit request header and a 32-bit write word. In return, the same frame hands back a 3-bit acknowledge and a 32-bit read word.

On the update strobe the header is decoded. A debug-port access reads or writes one of the local registers: control/status, bank select, or read buffer. An access-port access starts a request on a request/ready interface and holds it there until the port answers.

Reads are posted. A read's result is parked in the read buffer and comes out on the following scan. If a scan arrives while an access-port request is still outstanding, the block answers WAIT and drops the new request. The control/status register carries:
- sticky error and overrun flags;
- an overrun-detect enable;
- request/acknowledge pairs for the debug and system power domains.

Top module: `dbg_port_dr`

## Requirements
- R1: A scan is 35 bits shifted LSB first on `tdi`/`tdo`, one bit per cycle with `shiftDr` high. The outgoing frame has header bits [2:0]: bit 0 is read(1)/write(0) and bits [2:1] are the register address. The outgoing frame has the write word in bits [34:3]. The captured frame has the acknowledge in bits [2:0] and the read word in bits [34:3].
- R2: The acknowledge loaded on `captureDr` is 3'b010 (accepted) when no access-port request is outstanding, and 3'b001 (WAIT) when one is.
- R3: A read of any register other than the read buffer makes its result the read word of the next scan. This holds for debug-port addresses 0 to 2 and for all access-port addresses. Debug-port address 0 reads as zero.
- R4: A debug-port read of address 3 (read buffer) returns the last posted result, starts no access-port request, and leaves the read buffer unchanged.
- R5: A request answered with WAIT is discarded. The outstanding request keeps `apReq` high with `apAddr` and `apWdata` unchanged until `apReady`, and no extra request is issued.
- R6: A write to debug-port address 2 (bank select) keeps only bits [31:24] and [7:4]. `apSel` is bits [31:24]. `apAddr` is {bits [7:4], header address bits}.
- R7: Control/status (debug-port address 1) has these fields:
  - bit 0: overrun-detect enable;
  - bit 1: sticky overrun;
  - bit 5: sticky error;
  - bit 28: debug power request;
  - bit 29: debug power acknowledge;
  - bit 30: system power request;
  - bit 31: system power acknowledge.
  
  All other bits read 0. Writing 1 to bit 1 or bit 5 clears that flag.
- R8: With bit 0 set, a scan answered with WAIT sets the sticky overrun flag. With bit 0 clear, it does not.
- R9: An access-port request that completes with `apErr` high sets the sticky error flag.
- R10: `pwrReqDbg`/`pwrReqSys` follow control/status bits 28/30. Bits 29/31 read `pwrAckDbg`/`pwrAckSys`.
- R11: After reset all registers are zero: `apReq`, power requests and `tdo` are low, and the first scan returns 3'b010 with a zero read word.
- R12: An access-port request stays asserted until `apReady`. `apWrite` is the inverse of header bit 0 and `apWdata` is the frame's write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| selDp | input | 1 | Debug-port instruction is loaded |
| selAp | input | 1 | Access-port instruction is loaded |
| captureDr | input | 1 | Capture strobe, one cycle |
| shiftDr | input | 1 | Shift enable, one bit per cycle |
| updateDr | input | 1 | Update strobe, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| apReq | output | 1 | Access-port request outstanding |
| apWrite | output | 1 | Request is a write |
| apSel | output | APSEL_W | Selected access port |
| apAddr | output | BANK_W+2 | Word address inside the access port |
| apWdata | output | 32 | Write data |
| apRdata | input | 32 | Read data, valid with apReady |
| apReady | input | 1 | Request completes this cycle |
| apErr | input | 1 | Completing request failed |
| pwrReqDbg | output | 1 | Debug power-domain request |
| pwrReqSys | output | 1 | System power-domain request |
| pwrAckDbg | input | 1 | Debug power-domain acknowledge |
| pwrAckSys | input | 1 | System power-domain acknowledge |

## Verification
The main function is driven by a sequence of scans that interleave bank-select writes, access-port writes and reads in two banks, repeated read-buffer reads, and control/status writes and reads. Because every expected read word is the result of the previous read, a design that returns data one scan too early or too late, or that refreshes the read buffer on a read-buffer access, gives a different word. A slow access port is used to force WAIT answers with overrun detection both enabled and disabled, which separates a dropped request from one that is queued or that replaces the outstanding one. Errored completions, write-one-to-clear, withheld power acknowledges and a mid-run reset isolate each control/status field.

// File: rtl/dbgdr_pkg.sv
package dbgdr_pkg;
  localparam int HDR_W   = 3;
  localparam int DATA_W  = 32;
  localparam int FRAME_W = HDR_W + DATA_W;

  localparam logic [HDR_W-1:0] ACK_OK   = 3'b010;
  localparam logic [HDR_W-1:0] ACK_WAIT = 3'b001;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_SEL  = 2'd2,
    REG_RBUF = 2'd3
  } dpReg_e;

  // control/status field positions (decoded by the debugger)
  localparam int CS_ORUN_EN = 0;
  localparam int CS_ORUN    = 1;
  localparam int CS_ERR     = 5;
  localparam int CS_DBG_REQ = 28;
  localparam int CS_DBG_ACK = 29;
  localparam int CS_SYS_REQ = 30;
  localparam int CS_SYS_ACK = 31;

  typedef struct packed {
    logic capture;
    logic ackWait;
    logic shift;
    logic apAccept;
    logic wrCtrl;
    logic wrSel;
    logic postDp;
    logic apDone;
    logic setOrun;
    logic setErr;
  } drStrobe_t;
endpackage

// File: rtl/dbg_port_dr_ctrl.sv
module dbg_port_dr_ctrl
  import dbgdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             selDp,
  input  logic             selAp,
  input  logic [HDR_W-1:0] shHdr,
  input  logic             orunEn,
  input  logic             apReady,
  input  logic             apErr,
  output logic             apReq,
  output drStrobe_t        stb
);
  logic pending;
  logic waitLat;
  logic hit;
  logic discard;
  logic rnw;
  logic [1:0] regA;

  assign hit     = selDp | selAp;
  assign rnw     = shHdr[0];
  assign regA    = shHdr[2:1];
  assign discard = waitLat | pending;

  always_comb begin
    stb         = '0;
    stb.capture = captureDr & hit;
    stb.ackWait = pending;
    stb.shift   = shiftDr & hit;
    stb.apDone  = pending & apReady;
    stb.setErr  = pending & apReady & apErr;
    if (updateDr && hit) begin
      if (discard) begin
        stb.setOrun = orunEn;
      end else if (selDp) begin
        stb.postDp = rnw & (regA != REG_RBUF);
        stb.wrCtrl = ~rnw & (regA == REG_CTRL);
        stb.wrSel  = ~rnw & (regA == REG_SEL);
      end else begin
        stb.apAccept = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      waitLat <= 1'b0;
    end else begin
      if (stb.capture)
        waitLat <= pending;
      else if (updateDr && hit)
        waitLat <= 1'b0;
      if (stb.apAccept)
        pending <= 1'b1;
      else if (stb.apDone)
        pending <= 1'b0;
    end
  end

  assign apReq = pending;

  // R12
  ap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apReq && !apReady) |=> apReq);

  // R5
  ap_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(apReq) |-> $past(updateDr && selAp && !selDp));
endmodule

// File: rtl/dbg_port_dr_dp.sv
module dbg_port_dr_dp
  import dbgdr_pkg::*;
#(
  parameter int APSEL_W   = 8,
  parameter int BANK_W    = 4,
  parameter int AP_ADDR_W = BANK_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  drStrobe_t            stb,
  input  logic                 tdi,
  output logic                 tdo,
  output logic [HDR_W-1:0]     shHdr,
  output logic                 orunEn,
  input  logic                 pwrAckDbg,
  input  logic                 pwrAckSys,
  output logic                 pwrReqDbg,
  output logic                 pwrReqSys,
  input  logic [DATA_W-1:0]    apRdata,
  output logic [APSEL_W-1:0]   apSel,
  output logic [AP_ADDR_W-1:0] apAddr,
  output logic                 apWrite,
  output logic [DATA_W-1:0]    apWdata
);
  localparam int BANK_LSB = 4;

  logic [FRAME_W-1:0] shReg;
  logic [DATA_W-1:0]  shData;
  logic [DATA_W-1:0]  rdBuf;
  logic [DATA_W-1:0]  selReg;
  logic [DATA_W-1:0]  selMask;
  logic [DATA_W-1:0]  reqData;
  logic [DATA_W-1:0]  ctrlView;
  logic [DATA_W-1:0]  dpView;
  logic [1:0]         reqAddr;
  logic               reqRnw;
  logic               orunEnR;
  logic               stickyOrun;
  logic               stickyErr;
  logic               dbgReq;
  logic               sysReq;

  assign shHdr  = shReg[HDR_W-1:0];
  assign shData = shReg[FRAME_W-1:HDR_W];
  assign tdo    = shReg[0];

  for (genvar i = 0; i < DATA_W; i++) begin : gMask
    assign selMask[i] = (i >= DATA_W - APSEL_W) ||
                        ((i >= BANK_LSB) && (i < BANK_LSB + BANK_W));
  end

  always_comb begin
    ctrlView             = '0;
    ctrlView[CS_ORUN_EN] = orunEnR;
    ctrlView[CS_ORUN]    = stickyOrun;
    ctrlView[CS_ERR]     = stickyErr;
    ctrlView[CS_DBG_REQ] = dbgReq;
    ctrlView[CS_DBG_ACK] = pwrAckDbg;
    ctrlView[CS_SYS_REQ] = sysReq;
    ctrlView[CS_SYS_ACK] = pwrAckSys;
  end

  always_comb begin
    case (shHdr[2:1])
      REG_CTRL: dpView = ctrlView;
      REG_SEL:  dpView = selReg;
      default:  dpView = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg      <= '0;
      rdBuf      <= '0;
      selReg     <= '0;
      reqData    <= '0;
      reqAddr    <= '0;
      reqRnw     <= 1'b0;
      orunEnR    <= 1'b0;
      dbgReq     <= 1'b0;
      sysReq     <= 1'b0;
      stickyOrun <= 1'b0;
      stickyErr  <= 1'b0;
    end else begin
      if (stb.capture)
        shReg <= {rdBuf, (stb.ackWait ? ACK_WAIT : ACK_OK)};
      else if (stb.shift)
        shReg <= {tdi, shReg[FRAME_W-1:1]};

      if (stb.apAccept) begin
        reqRnw  <= shHdr[0];
        reqAddr <= shHdr[2:1];
        reqData <= shData;
      end

      if (stb.postDp)
        rdBuf <= dpView;
      else if (stb.apDone && reqRnw)
        rdBuf <= apRdata;

      if (stb.wrSel)
        selReg <= shData & selMask;

      if (stb.wrCtrl) begin
        orunEnR <= shData[CS_ORUN_EN];
        dbgReq  <= shData[CS_DBG_REQ];
        sysReq  <= shData[CS_SYS_REQ];
      end

      stickyOrun <= stb.setOrun | (stickyOrun & ~(stb.wrCtrl & shData[CS_ORUN]));
      stickyErr  <= stb.setErr  | (stickyErr  & ~(stb.wrCtrl & shData[CS_ERR]));
    end
  end

  assign orunEn    = orunEnR;
  assign pwrReqDbg = dbgReq;
  assign pwrReqSys = sysReq;
  assign apSel     = selReg[DATA_W-1 -: APSEL_W];
  assign apAddr    = {selReg[BANK_LSB +: BANK_W], reqAddr};
  assign apWrite   = ~reqRnw;
  assign apWdata   = reqData;

  // R2
  ack_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> ((shReg[2:0] == ACK_OK) || (shReg[2:0] == ACK_WAIT)));

  // R8
  orun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyOrun) |-> $past(stb.setOrun && orunEnR));

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyErr) |-> $past(stb.setErr));
endmodule

// File: rtl/dbg_port_dr.sv
module dbg_port_dr
  import dbgdr_pkg::*;
#(
  parameter int APSEL_W = 8,
  parameter int BANK_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selDp,
  input  logic                selAp,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                tdi,
  output logic                tdo,
  output logic                apReq,
  output logic                apWrite,
  output logic [APSEL_W-1:0]  apSel,
  output logic [BANK_W+1:0]   apAddr,
  output logic [31:0]         apWdata,
  input  logic [31:0]         apRdata,
  input  logic                apReady,
  input  logic                apErr,
  output logic                pwrReqDbg,
  output logic                pwrReqSys,
  input  logic                pwrAckDbg,
  input  logic                pwrAckSys
);
  localparam int AP_ADDR_W = BANK_W + 2;

  drStrobe_t        stb;
  logic [HDR_W-1:0] shHdr;
  logic             orunEn;

  dbg_port_dr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .selDp     (selDp),
    .selAp     (selAp),
    .shHdr     (shHdr),
    .orunEn    (orunEn),
    .apReady   (apReady),
    .apErr     (apErr),
    .apReq     (apReq),
    .stb       (stb)
  );

  dbg_port_dr_dp #(
    .APSEL_W   (APSEL_W),
    .BANK_W    (BANK_W),
    .AP_ADDR_W (AP_ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tdi       (tdi),
    .tdo       (tdo),
    .shHdr     (shHdr),
    .orunEn    (orunEn),
    .pwrAckDbg (pwrAckDbg),
    .pwrAckSys (pwrAckSys),
    .pwrReqDbg (pwrReqDbg),
    .pwrReqSys (pwrReqSys),
    .apRdata   (apRdata),
    .apSel     (apSel),
    .apAddr    (apAddr),
    .apWrite   (apWrite),
    .apWdata   (apWdata)
  );

  // R5
  req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apReq && !apReady) |=> ($stable(apAddr) && $stable(apWdata) && $stable(apWrite)));
endmodule

// File: tb/sim_dbg_port_dr.sv
`timescale 1ns/1ps
module sim_dbg_port_dr;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selDp = 1'b0, selAp = 1'b0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo, apReq, apWrite, pwrReqDbg, pwrReqSys;
  logic [7:0]  apSel;
  logic [5:0]  apAddr;
  logic [31:0] apWdata;
  logic [31:0] apRdata = '0;
  logic apReady = 1'b0, apErr = 1'b0;
  logic pwrAckDbg = 1'b0, pwrAckSys = 1'b0;

  int applied = 0;
  int miscompares = 0;
  int apLat = 0;
  int apCnt = 0;
  int reqCount = 0;
  logic ackEn = 1'b1;
  logic [7:0]  lastSel = '0;
  logic [5:0]  lastAddr = '0;
  logic [31:0] mem [64];

  always #2.5 clk = ~clk;

  dbg_port_dr u0 (
    .clk(clk), .rstN(rstN), .selDp(selDp), .selAp(selAp),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdi(tdi), .tdo(tdo), .apReq(apReq), .apWrite(apWrite),
    .apSel(apSel), .apAddr(apAddr), .apWdata(apWdata), .apRdata(apRdata),
    .apReady(apReady), .apErr(apErr), .pwrReqDbg(pwrReqDbg),
    .pwrReqSys(pwrReqSys), .pwrAckDbg(pwrAckDbg), .pwrAckSys(pwrAckSys)
  );

  // access-port model: fixed latency, error at word address 6'h3F
  always @(posedge clk) begin
    apReady <= 1'b0;
    apErr   <= 1'b0;
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h5A5A0000 | i;
      apCnt <= 0;
    end else if (apReq && !apReady) begin
      if (apCnt >= apLat) begin
        apReady  <= 1'b1;
        apErr    <= (apAddr == 6'h3F);
        apCnt    <= 0;
        lastSel  <= apSel;
        lastAddr <= apAddr;
        reqCount <= reqCount + 1;
        if (apWrite) mem[apAddr] <= apWdata;
        else         apRdata <= mem[apAddr];
      end else begin
        apCnt <= apCnt + 1;
      end
    end
  end

  // power model: acknowledge follows request one cycle later
  always @(posedge clk) begin
    pwrAckDbg <= pwrReqDbg & ackEn;
    pwrAckSys <= pwrReqSys & ackEn;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic scan(input logic ap, input logic rnw, input logic [1:0] a,
                      input logic [31:0] d, output logic [2:0] ack, output logic [31:0] rd);
    logic [34:0] o;
    logic [34:0] i;
    o = {d, a, rnw};
    i = '0;
    repeat (4) @(negedge clk);
    selDp = ~ap; selAp = ap; captureDr = 1'b1;
    @(negedge clk);
    captureDr = 1'b0;
    for (int b = 0; b < 35; b++) begin
      i[b] = tdo; tdi = o[b]; shiftDr = 1'b1;
      @(negedge clk);
    end
    shiftDr = 1'b0; updateDr = 1'b1;
    @(negedge clk);
    updateDr = 1'b0;
    ack = i[2:0];
    rd  = i[34:3];
  endtask

  task automatic waitIdle();
    while (apReq) @(negedge clk);
  endtask

  // {ap, rnw, addr, wdata, expected read word}
  localparam logic [67:0] VEC [17] = '{
    {1'b0, 1'b0, 2'd2, 32'h12ABCD3F, 32'h00000000},
    {1'b0, 1'b1, 2'd2, 32'h00000000, 32'h00000000},
    {1'b0, 1'b1, 2'd3, 32'h00000000, 32'h12000030},
    {1'b1, 1'b0, 2'd1, 32'hDEADBEEF, 32'h12000030},
    {1'b1, 1'b0, 2'd2, 32'hCAFEF00D, 32'h12000030},
    {1'b1, 1'b1, 2'd1, 32'h00000000, 32'h12000030},
    {1'b1, 1'b1, 2'd2, 32'h00000000, 32'hDEADBEEF},
    {1'b0, 1'b1, 2'd3, 32'h00000000, 32'hCAFEF00D},
    {1'b0, 1'b1, 2'd3, 32'h00000000, 32'hCAFEF00D},
    {1'b0, 1'b0, 2'd2, 32'h00000000, 32'hCAFEF00D},
    {1'b1, 1'b1, 2'd1, 32'h00000000, 32'hCAFEF00D},
    {1'b0, 1'b1, 2'd1, 32'h00000000, 32'h5A5A0001},
    {1'b0, 1'b0, 2'd1, 32'h50000001, 32'h00000000},
    {1'b0, 1'b1, 2'd1, 32'h00000000, 32'h00000000},
    {1'b0, 1'b1, 2'd3, 32'h00000000, 32'hF0000001},
    {1'b0, 1'b1, 2'd0, 32'h00000000, 32'hF0000001},
    {1'b0, 1'b1, 2'd3, 32'h00000000, 32'h00000000}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin : main
    logic [2:0]  ack;
    logic [31:0] rd;
    int cnt0;
    repeat (3) @(negedge clk);
    chk("R11 reset apReq", {31'b0, apReq}, 32'h0);
    chk("R11 reset tdo", {31'b0, tdo}, 32'h0);
    chk("R11 reset pwr", {30'b0, pwrReqSys, pwrReqDbg}, 32'h0);
    rstN = 1'b1;

    // R1 R3 R4 table of posted accesses
    for (int v = 0; v < 17; v++) begin
      scan(VEC[v][67], VEC[v][66], VEC[v][65:64], VEC[v][63:32], ack, rd);
      chk($sformatf("R2 vector %0d ack", v), {29'b0, ack}, 32'h2);
      chk($sformatf("R1 R3 R4 vector %0d data", v), rd, VEC[v][31:0]);
    end
    chk("R12 AP write landed", mem[13], 32'hDEADBEEF);

    // WAIT with overrun detect on
    apLat = 100;
    cnt0 = reqCount;
    scan(1'b1, 1'b0, 2'd0, 32'h11112222, ack, rd);
    chk("R2 first ack", {29'b0, ack}, 32'h2);
    scan(1'b1, 1'b1, 2'd1, 32'h0, ack, rd);
    chk("R2 wait ack", {29'b0, ack}, 32'h1);
    chk("R5 request still held", {31'b0, apReq}, 32'h1);
    chk("R5 address kept", {26'b0, apAddr}, 32'h0);
    chk("R12 write flag", {31'b0, apWrite}, 32'h1);
    chk("R12 write data", apWdata, 32'h11112222);
    waitIdle();
    apLat = 0;
    chk("R5 single request", reqCount - cnt0, 32'd1);
    chk("R12 wait write landed", mem[0], 32'h11112222);
    scan(1'b0, 1'b1, 2'd1, 32'h0, ack, rd);
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R8 overrun set", rd, 32'hF0000003);

    // write-one-to-clear overrun
    scan(1'b0, 1'b0, 2'd1, 32'h50000003, ack, rd);
    scan(1'b0, 1'b1, 2'd1, 32'h0, ack, rd);
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R7 overrun cleared", rd, 32'hF0000001);

    // WAIT with overrun detect off
    scan(1'b0, 1'b0, 2'd1, 32'h50000000, ack, rd);
    apLat = 100;
    scan(1'b1, 1'b0, 2'd2, 32'h33334444, ack, rd);
    scan(1'b1, 1'b0, 2'd3, 32'h55556666, ack, rd);
    chk("R2 wait ack detect off", {29'b0, ack}, 32'h1);
    waitIdle();
    apLat = 0;
    chk("R5 discarded write absent", mem[3], 32'h5A5A0003);
    scan(1'b0, 1'b1, 2'd1, 32'h0, ack, rd);
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R8 no overrun when disabled", rd, 32'hF0000000);

    // bank select masking, port select, error
    scan(1'b0, 1'b0, 2'd2, 32'hAB0000F5, ack, rd);
    scan(1'b0, 1'b1, 2'd2, 32'h0, ack, rd);
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R6 select mask", rd, 32'hAB0000F0);
    scan(1'b1, 1'b0, 2'd3, 32'h0, ack, rd);
    waitIdle();
    chk("R6 apSel", {24'b0, lastSel}, 32'hAB);
    chk("R6 apAddr", {26'b0, lastAddr}, 32'h3F);
    scan(1'b0, 1'b1, 2'd1, 32'h0, ack, rd);
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R9 sticky error", rd, 32'hF0000020);
    scan(1'b0, 1'b0, 2'd1, 32'h50000020, ack, rd);
    scan(1'b0, 1'b1, 2'd1, 32'h0, ack, rd);
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R7 error cleared", rd, 32'hF0000000);

    // power handshake
    ackEn = 1'b0;
    scan(1'b0, 1'b1, 2'd1, 32'h0, ack, rd);
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R10 acks withheld", rd, 32'h50000000);
    chk("R10 request pins", {30'b0, pwrReqSys, pwrReqDbg}, 32'h3);
    scan(1'b0, 1'b0, 2'd1, 32'h40000000, ack, rd);
    chk("R10 debug request dropped", {30'b0, pwrReqSys, pwrReqDbg}, 32'h2);
    ackEn = 1'b1;

    // reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 reset pwr pins", {30'b0, pwrReqSys, pwrReqDbg}, 32'h0);
    chk("R11 reset apReq mid-run", {31'b0, apReq}, 32'h0);
    rstN = 1'b1;
    scan(1'b0, 1'b1, 2'd3, 32'h0, ack, rd);
    chk("R11 first ack", {29'b0, ack}, 32'h2);
    chk("R11 first data", rd, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule